// File: doc/BRIEF.md
# Audio Clock Divider and Frame-Length Checker

This block derives the three timing strobes of a serial audio port from a fast kernel clock. These are a master-clock strobe, a bit-clock strobe and a frame-start strobe. Each output is a single-cycle enable in the kernel clock domain, so downstream logic stays on one clock and qualifies its registers with these strobes. A 6-bit divider scales the kernel clock down. Codes 0 and 1 both mean divide-by-one.

There are two ways to reach the bit clock. With the master clock switched off, the divided kernel clock is the bit clock, and a frame spans FRL+1 bit clocks. With the master clock in use, the divided kernel clock is the master clock. The bit clock is then the master clock divided again, so that one frame spans 256 master clocks, or 512 when the oversampling select is high.

When the port is enabled as a bus master with the master clock in use, the block checks the frame-length field. Only lengths of 8, 16, 32, 64, 128 or 256 bit clocks are legal. An illegal length raises a sticky error flag, which stays set until a clear strobe. While the enable is low, all counters stay at zero and no strobe is issued.

Top module: `aud_clkgen`

## Requirements
- R1: Divider codes 0 and 1 both divide by one: with the master clock off and the block enabled, a bit-clock strobe appears on every kernel cycle.
- R2: For a divider code D of 2 or more, the divided strobe fires on the D-th enabled cycle and every D cycles after that. In master-clock mode this strobe is `mclk_tick`.
- R3: When `no_mclk` is 1, `mclk_tick` never fires and `bclk_tick` equals the divided strobe.
- R4: When `no_mclk` is 0 and FRL+1 is legal, `bclk_tick` fires on every R-th master-clock strobe. R is 256/(FRL+1) when `osr_hi` is 0, and 512/(FRL+1) when `osr_hi` is 1.
- R5: `frame_tick` coincides with the first bit-clock strobe after enable, and then with every (FRL+1)-th bit-clock strobe.
- R6: One cycle after a rising edge of `en`, `wrong_cfg` is set if `slave_mode` is 0, `no_mclk` is 0, and FRL+1 is not one of 8, 16, 32, 64, 128 or 256.
- R7: `wrong_cfg` is not set when `slave_mode` is 1, when `no_mclk` is 1, or when the length is legal.
- R8: `wrong_cfg` holds its value until `flag_clr` is sampled high, and then reads 0 on the next cycle. A set condition in the same cycle wins over the clear. Reset clears the flag.
- R9: While `en` is low, all three strobes are 0. The counters restart from zero, so the timing after re-enable is the same as after the first enable.
- R10: In master-clock mode with an illegal length, the bit-clock strobe equals the master-clock strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low holds all counters at zero |
| div_val | input | 6 | Divider code (0 and 1 both divide by one) |
| osr_hi | input | 1 | Oversampling select: 0 gives 256, 1 gives 512 master clocks per frame |
| no_mclk | input | 1 | 1 turns the master clock off, so the bit clock comes straight from the divider |
| slave_mode | input | 1 | 1 when the port takes its clocks from outside; this disables the length check |
| frl | input | 8 | Frame length minus one, in bit clocks |
| flag_clr | input | 1 | Clear strobe for the error flag |
| mclk_tick | output | 1 | Master-clock enable pulse |
| bclk_tick | output | 1 | Bit-clock enable pulse |
| frame_tick | output | 1 | Frame-start enable pulse |
| wrong_cfg | output | 1 | Sticky illegal-frame-length flag |

## Verification
The assertions assume that the divider, oversampling, mode and frame-length inputs stay fixed while `en` is high. A mid-run change could break the spacing of the divided strobe and the counter invariants. The stimulus respects this: every configuration change happens while `en` is held low for at least two cycles. The enable is only dropped and raised between those settings, or mid-run with the configuration unchanged. `flag_clr` carries no assumption, and it is pulsed both alone and in the same cycle as a set condition.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int DIV_W   = 6;
    localparam int FRL_W   = 8;
    localparam int MIN_LOG = 3;
    localparam int OSR_LOG = 8;
    localparam int RAT_W   = OSR_LOG + 1 - MIN_LOG;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             osr_hi;
        logic             no_mclk;
        logic             slave;
        logic [FRL_W-1:0] frl;
    } clk_cfg_t;

    // terminal count of the prescaler; codes 0 and 1 both give zero
    function automatic logic [DIV_W-1:0] div_last(input logic [DIV_W-1:0] d);
        return (d <= DIV_W'(1)) ? '0 : d - DIV_W'(1);
    endfunction

    function automatic logic frame_legal(input logic [FRL_W-1:0] f);
        logic ok;
        ok = 1'b0;
        for (int i = MIN_LOG; i <= FRL_W; i++)
            if (int'(f) + 1 == (1 << i)) ok = 1'b1;
        return ok;
    endfunction

    // master clocks per bit clock, minus one; illegal lengths give zero
    function automatic logic [RAT_W-1:0] ratio_last(input logic [FRL_W-1:0] f,
                                                    input logic osr);
        int r;
        r = 0;
        for (int i = MIN_LOG; i <= FRL_W; i++)
            if (int'(f) + 1 == (1 << i))
                r = (1 << ((osr ? OSR_LOG + 1 : OSR_LOG) - i)) - 1;
        return RAT_W'(r);
    endfunction

endpackage

// File: rtl/aclk_modcnt.sv
module aclk_modcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic         at_first,
    output logic         at_last
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (step)
            cnt <= (cnt >= last) ? '0 : cnt + W'(1);
    end

    assign at_first = (cnt == '0);
    assign at_last  = (cnt >= last);

    // R9: a clear always brings the count back to its first position
    a_r9_clr_restarts: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> at_first);

endmodule

// File: rtl/aclk_cfg_check.sv
module aclk_cfg_check
    import aclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             slave,
    input  logic             no_mclk,
    input  logic [FRL_W-1:0] frl,
    input  logic             clr,
    output logic             flag
);

    logic en_q;
    logic rise;
    logic set_now;

    assign rise    = en & ~en_q;
    assign set_now = rise & ~slave & ~no_mclk & ~frame_legal(frl);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            flag <= 1'b0;
        end else begin
            en_q <= en;
            if (set_now)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    // R8: without a clear the flag never drops
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R8: a clear while disabled cannot meet a set and empties the flag
    a_r8_clear_idle: assert property (@(posedge clk) disable iff (rst)
        (clr && !en) |=> !flag);

    // R7: the flag only rises after an enabled master cycle with the master clock on
    a_r7_rise_needs_master: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(en && !slave && !no_mclk));

endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
    import aclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_val,
    input  logic             osr_hi,
    input  logic             no_mclk,
    input  logic             slave_mode,
    input  logic [FRL_W-1:0] frl,
    input  logic             flag_clr,
    output logic             mclk_tick,
    output logic             bclk_tick,
    output logic             frame_tick,
    output logic             wrong_cfg
);

    clk_cfg_t         cfg;
    logic             idle;
    logic             pre_last;
    logic             base_tick;
    logic             rat_last;
    logic             fr_first;
    logic [RAT_W-1:0] rat_term;

    assign cfg.div     = div_val;
    assign cfg.osr_hi  = osr_hi;
    assign cfg.no_mclk = no_mclk;
    assign cfg.slave   = slave_mode;
    assign cfg.frl     = frl;

    assign idle = ~en;

    // kernel prescaler
    logic pre_first_unused;
    aclk_modcnt #(.W(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .clr(idle), .step(en),
        .last(div_last(cfg.div)),
        .at_first(pre_first_unused), .at_last(pre_last)
    );
    assign base_tick = en & pre_last;

    // master-to-bit ratio stage, collapsed to one when the master clock is off
    assign rat_term = cfg.no_mclk ? '0 : ratio_last(cfg.frl, cfg.osr_hi);
    logic rat_first_unused;
    aclk_modcnt #(.W(RAT_W)) u_rat (
        .clk(clk), .rst(rst), .clr(idle), .step(base_tick & ~cfg.no_mclk),
        .last(rat_term),
        .at_first(rat_first_unused), .at_last(rat_last)
    );

    assign mclk_tick = base_tick & ~cfg.no_mclk;
    assign bclk_tick = base_tick & (cfg.no_mclk | rat_last);

    // frame counter in bit clocks
    logic fr_last_unused;
    aclk_modcnt #(.W(FRL_W)) u_frm (
        .clk(clk), .rst(rst), .clr(idle), .step(bclk_tick),
        .last(cfg.frl),
        .at_first(fr_first), .at_last(fr_last_unused)
    );
    assign frame_tick = bclk_tick & fr_first;

    aclk_cfg_check u_chk (
        .clk(clk), .rst(rst), .en(en), .slave(cfg.slave),
        .no_mclk(cfg.no_mclk), .frl(cfg.frl), .clr(flag_clr),
        .flag(wrong_cfg)
    );

    // R9: nothing pulses while disabled
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(mclk_tick || bclk_tick || frame_tick));

    // R3: the master strobe is silent when the master clock is off
    a_r3_no_mclk_silent: assert property (@(posedge clk) disable iff (rst)
        no_mclk |-> !mclk_tick);

    // R5: a frame start always sits on a bit-clock strobe
    a_r5_frame_on_bit: assert property (@(posedge clk) disable iff (rst)
        frame_tick |-> bclk_tick);

    // R4: in master-clock mode every bit strobe sits on a master strobe
    a_r4_bit_on_master: assert property (@(posedge clk) disable iff (rst)
        (!no_mclk && bclk_tick) |-> mclk_tick);

    // R10: an illegal length in master-clock mode passes the master strobe through
    a_r10_illegal_passthru: assert property (@(posedge clk) disable iff (rst)
        (!no_mclk && !frame_legal(frl) && mclk_tick) |-> bclk_tick);

    // R2: a divider above one never gives two strobes in a row
    a_r2_spacing: assert property (@(posedge clk) disable iff (rst)
        (mclk_tick && div_val > DIV_W'(1)) |=> !mclk_tick);

endmodule

// File: tb/tb_aud_clkgen.sv
module tb_aud_clkgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [5:0] div_val = '0;
    logic       osr_hi = 1'b0;
    logic       no_mclk = 1'b1;
    logic       slave_mode = 1'b0;
    logic [7:0] frl = 8'd7;
    logic       flag_clr = 1'b0;
    logic       mclk_tick, bclk_tick, frame_tick, wrong_cfg;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    int    m = 0;
    bit    mflag = 1'b0;
    bit    en_prev = 1'b0;
    string tag_b = "R1";
    string tag_f = "R7";

    always #5 clk = ~clk;

    aud_clkgen dut (
        .clk(clk), .rst(rst), .en(en), .div_val(div_val), .osr_hi(osr_hi),
        .no_mclk(no_mclk), .slave_mode(slave_mode), .frl(frl),
        .flag_clr(flag_clr), .mclk_tick(mclk_tick), .bclk_tick(bclk_tick),
        .frame_tick(frame_tick), .wrong_cfg(wrong_cfg)
    );

    function automatic bit legal_len(int n);
        return n == 8 || n == 16 || n == 32 || n == 64 || n == 128 || n == 256;
    endfunction

    task automatic cmp(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b time=%0t", req, what, act, exp, $time);
        end
    endtask

    // one kernel cycle: update the model at the edge, compare at the falling edge
    task automatic tick();
        int  d, n, r, p, c;
        bit  e_base, e_m, e_b, e_f;
        @(posedge clk);
        n = int'(frl) + 1;
        if (rst) begin
            m = 0; mflag = 1'b0; en_prev = 1'b0;
        end else begin
            if (en && !en_prev && !slave_mode && !no_mclk && !legal_len(n))
                mflag = 1'b1;
            else if (flag_clr)
                mflag = 1'b0;
            en_prev = en;
            m = en ? m + 1 : 0;
        end
        @(negedge clk);
        d = (div_val <= 1) ? 1 : int'(div_val);
        r = no_mclk ? 1 : (legal_len(n) ? (osr_hi ? 512 : 256) / n : 1);
        p = d * r;
        c = m + 1;
        e_base = en && !rst && (c % d == 0);
        e_m    = e_base && !no_mclk;
        e_b    = en && !rst && (c % p == 0);
        e_f    = e_b && (((c / p) - 1) % n == 0);
        if (!en) begin
            cmp("R9", "mclk_tick", mclk_tick, 1'b0);
            cmp("R9", "bclk_tick", bclk_tick, 1'b0);
            cmp("R9", "frame_tick", frame_tick, 1'b0);
        end else begin
            cmp(no_mclk ? "R3" : "R2", "mclk_tick", mclk_tick, e_m);
            cmp(tag_b, "bclk_tick", bclk_tick, e_b);
            cmp("R5", "frame_tick", frame_tick, e_f);
        end
        cmp(tag_f, "wrong_cfg", wrong_cfg, mflag);
    endtask

    task automatic run_cfg(int dv, bit osr, bit nm, bit sl, int fl, int cycles,
                           string tb, string tf);
        en = 1'b0;
        tick();
        tick();
        div_val = 6'(dv); osr_hi = osr; no_mclk = nm; slave_mode = sl; frl = 8'(fl);
        tag_b = tb; tag_f = tf;
        en = 1'b1;
        for (int i = 0; i < cycles; i++) tick();
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        tick();
        cmp("R8", "flag after clear", wrong_cfg, 1'b0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tag_f = "R8";
        for (int i = 0; i < 3; i++) tick();
        rst = 1'b0;
        tick();
        cmp("R9", "reset mclk_tick", mclk_tick, 1'b0);
        cmp("R9", "reset bclk_tick", bclk_tick, 1'b0);
        cmp("R8", "reset wrong_cfg", wrong_cfg, 1'b0);

        // R1: codes 0 and 1 both divide by one
        run_cfg(0, 0, 1, 0, 7, 40, "R1", "R7");
        run_cfg(1, 0, 1, 0, 7, 40, "R1", "R7");
        // R3: bypass with divider 5 and an odd frame
        run_cfg(5, 0, 1, 0, 9, 200, "R3", "R7");
        // R4: master mode, ratio 4, then R9 restart mid-run
        run_cfg(3, 0, 0, 0, 63, 50, "R4", "R7");
        en = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        en = 1'b1;
        for (int i = 0; i < 2000; i++) tick();
        // R4: oversampled, ratio 32
        run_cfg(2, 1, 0, 0, 15, 2200, "R4", "R7");
        // R4: largest ratio 64 at divider 1
        run_cfg(1, 1, 0, 0, 7, 1100, "R4", "R7");
        // R4: longest legal frame, ratio 1
        run_cfg(4, 0, 0, 0, 255, 1200, "R4", "R7");
        cmp("R7", "legal 256 no flag", wrong_cfg, 1'b0);

        // R6 and R10: illegal length as master with master clock
        run_cfg(1, 0, 0, 0, 9, 100, "R10", "R6");
        cmp("R6", "flag on illegal length", wrong_cfg, 1'b1);
        // R8: stays set while disabled
        en = 1'b0;
        for (int i = 0; i < 4; i++) tick();
        cmp("R8", "flag sticky", wrong_cfg, 1'b1);
        clear_flag();

        // R7: slave mode and no-master-clock mode never flag
        run_cfg(2, 0, 0, 1, 9, 60, "R10", "R7");
        cmp("R7", "slave no flag", wrong_cfg, 1'b0);
        run_cfg(2, 0, 1, 0, 9, 60, "R3", "R7");
        cmp("R7", "no master clock no flag", wrong_cfg, 1'b0);

        // R6: power of two below eight is illegal
        run_cfg(3, 1, 0, 0, 3, 60, "R10", "R6");
        cmp("R6", "flag on length 4", wrong_cfg, 1'b1);
        clear_flag();

        // R8: set in the same cycle as clear wins
        en = 1'b0;
        tick();
        tag_f = "R8";
        en = 1'b1;
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        tick();
        cmp("R8", "set beats clear", wrong_cfg, 1'b1);
        clear_flag();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule